// File: doc/BRIEF.md
# Reset Stretch and Initialization Sequencer

This block takes an asynchronous, active-low reset pin and turns it into an ordered start-up for the rest of the device. While the pin is low, every stage is held cleared. After the pin goes high, the release passes through a synchronizer into the system clock domain. The internal reset is then held for a fixed number of clock cycles. With the default 81 cycles at a 20.25 MHz system clock, this hold is 4 µs. The clock dividers are outside this block, and the reset does not touch them.

After the hold, the sequencer enters an initialization phase. In this phase an on-chip register loader, which is outside this block, programs the device. The sequencer flags the serial-bus slave as busy, so that the slave refuses accesses addressed to this device. Bus traffic to other devices is not affected. When the loader reports completion on `init_done`, the sequencer enters normal operation. The sequencer also tells the horizontal output generator when to run from its standby clock.

Top module: `rstseq_top`

## Requirements
- R1: At every rising clock edge after `rst_pin_n` goes low, and for as long as it stays low, the outputs take these values: `int_rst`=1, `hout_standby`=1, `serial_busy`=1, `init_active`=0.
- R2: Count the rising edges after `rst_pin_n` goes high, starting with the first one. `int_rst` stays high through the first SYNC_STAGES+HOLD_CYCLES of these edges and goes low at edge SYNC_STAGES+HOLD_CYCLES+1. With the defaults (2 and 81), it goes low at edge 84.
- R3: `init_active` goes high at the same edge at which `int_rst` goes low. It stays high until `init_done` has been sampled high.
- R4: `serial_busy` is high during reset, during the hold and during initialization. It goes low only once normal operation is reached.
- R5: `hout_standby` is high exactly when `int_rst` is high.
- R6: If `init_done` is sampled high at a rising edge while `init_active` is high, then at that edge `init_active` and `serial_busy` both go low.
- R7: `init_done` has no effect outside initialization. Holding it high during reset or the hold neither shortens nor skips any phase. Toggling it in normal operation changes no output.
- R8: If `rst_pin_n` goes low during any phase, the next rising edge returns the outputs to the R1 values. The whole sequence then runs again from the start after the next release.
- R9: Once normal operation is reached, all four outputs stay low for as long as `rst_pin_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_pin_n | input | 1 | External reset pin, asynchronous, active low |
| init_done | input | 1 | Register loader reports completion |
| int_rst | output | 1 | Internal reset for the device core, active high |
| init_active | output | 1 | Initialization phase in progress |
| serial_busy | output | 1 | Serial slave must refuse accesses to this device |
| hout_standby | output | 1 | Horizontal output generator selects its standby clock |

## Verification
Every output is a register driven from the phase state. A wrong phase therefore appears on all four outputs at the very next edge, as a pattern that is not legal, for example `init_active` and `int_rst` high together. A hold counter that is off by one moves the falling edge of `int_rst` by one cycle. The bench counts this edge exactly, both in a reduced configuration and at the default length. A fault in the synchronizer or in the abort path shows up as a missing or late return to the reset pattern on the first edge after the pin falls.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_HOLD  = 2'd1,
    ST_INIT  = 2'd2,
    ST_RUN   = 2'd3
  } rstseq_state_e;
endpackage

// File: rtl/rstseq_sync.sv
// Reset synchronizer: clears at once on a low pin, and releases only after
// a run of clock edges, so that the release is synchronous to clk.
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic pin_n,
  output logic rst_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n) chain <= '0;
        else        chain <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_o = ~chain[STAGES-1];
endmodule

// File: rtl/rstseq_hold_timer.sv
// Counts the cycles spent in the hold phase. expired is high in the last
// of HOLD_CYCLES cycles.
module rstseq_hold_timer #(
  parameter int CNT_W       = 7,
  parameter int HOLD_CYCLES = 81
) (
  input  logic clk,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr || !run)      cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);
endmodule

// File: rtl/rstseq_fsm.sv
// Phase controller. The outputs are registered from the next state.
module rstseq_fsm
  import rstseq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          hold_expired,
  input  logic          init_done,
  output rstseq_state_e state_q,
  output logic          int_rst_q,
  output logic          init_q,
  output logic          busy_q,
  output logic          stby_q
);
  rstseq_state_e nxt;

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_RESET: nxt = ST_HOLD;
      ST_HOLD:  if (hold_expired) nxt = ST_INIT;
      ST_INIT:  if (init_done)    nxt = ST_RUN;
      ST_RUN:   nxt = ST_RUN;
      default:  nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_RESET;
      int_rst_q <= 1'b1;
      init_q    <= 1'b0;
      busy_q    <= 1'b1;
      stby_q    <= 1'b1;
    end else begin
      state_q   <= nxt;
      int_rst_q <= (nxt == ST_RESET) || (nxt == ST_HOLD);
      init_q    <= (nxt == ST_INIT);
      busy_q    <= (nxt != ST_RUN);
      stby_q    <= (nxt == ST_RESET) || (nxt == ST_HOLD);
    end
  end
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 81,
  parameter int CNT_W       = 7
) (
  input  logic clk,
  input  logic rst_pin_n,
  input  logic init_done,
  output logic int_rst,
  output logic init_active,
  output logic serial_busy,
  output logic hout_standby
);
  logic          rst_sync;
  logic          hold_expired;
  rstseq_state_e state;

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .pin_n (rst_pin_n),
    .rst_o (rst_sync)
  );

  rstseq_hold_timer #(.CNT_W(CNT_W), .HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk     (clk),
    .clr     (rst_sync),
    .run     (state == ST_HOLD),
    .expired (hold_expired)
  );

  rstseq_fsm u_fsm (
    .clk          (clk),
    .rst          (rst_sync),
    .hold_expired (hold_expired),
    .init_done    (init_done),
    .state_q      (state),
    .int_rst_q    (int_rst),
    .init_q       (init_active),
    .busy_q       (serial_busy),
    .stby_q       (hout_standby)
  );
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
  parameter int HOLD_CYCLES = 81
) (
  input logic clk,
  input logic rst_sync,
  input logic init_done,
  input logic int_rst,
  input logic init_active,
  input logic serial_busy,
  input logic hout_standby
);
  logic seen = 1'b0;
  int   held;

  always_ff @(posedge clk) begin
    seen <= 1'b1;
    if (rst_sync)     held <= 0;
    else if (int_rst) held <= held + 1;
  end

  // R1 / R8: a synchronized reset forces the reset pattern at the next edge
  a_r1_reset_pattern: assert property (@(posedge clk)
    seen && $past(rst_sync) |-> int_rst && serial_busy && hout_standby && !init_active);

  // R2: the hold lasts HOLD_CYCLES edges beyond the first edge after release
  a_r2_hold_length: assert property (@(posedge clk) disable iff (rst_sync)
    $fell(int_rst) |-> held == HOLD_CYCLES + 1);

  // R3: initialization starts exactly when the internal reset ends
  a_r3_init_follows: assert property (@(posedge clk) disable iff (rst_sync)
    $fell(int_rst) |-> init_active);

  // R4: the serial slave is busy throughout initialization
  a_r4_busy_in_init: assert property (@(posedge clk) disable iff (rst_sync)
    init_active |-> serial_busy);

  // R5: the standby clock select tracks the internal reset
  a_r5_standby: assert property (@(posedge clk) disable iff (rst_sync)
    hout_standby == int_rst);

  // R6: leaving busy needs a done seen during initialization
  a_r6_done_exit: assert property (@(posedge clk) disable iff (rst_sync)
    $fell(serial_busy) |-> $past(init_active) && $past(init_done));

  // R9: normal operation persists
  a_r9_run_holds: assert property (@(posedge clk) disable iff (rst_sync)
    !serial_busy |=> !serial_busy && !int_rst && !init_active);
endmodule

bind rstseq_top rstseq_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk          (clk),
  .rst_sync     (rst_sync),
  .init_done    (init_done),
  .int_rst      (int_rst),
  .init_active  (init_active),
  .serial_busy  (serial_busy),
  .hout_standby (hout_standby)
);

// File: tb/tb_rstseq_top.sv
module tb_rstseq_top;
  localparam int H  = 5;
  localparam int SS = 2;

  // Output patterns {int_rst, init_active, serial_busy, hout_standby}
  localparam logic [3:0] P_RST  = 4'b1011;
  localparam logic [3:0] P_INIT = 4'b0110;
  localparam logic [3:0] P_RUN  = 4'b0000;

  logic clk = 1'b0;
  logic rst_pin_n = 1'b1;
  logic init_done = 1'b0;
  logic int_rst, init_active, serial_busy, hout_standby;
  logic f_int_rst, f_init_active, f_serial_busy, f_hout_standby;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rstseq_top #(.SYNC_STAGES(SS), .HOLD_CYCLES(H), .CNT_W(3)) dut (
    .clk(clk), .rst_pin_n(rst_pin_n), .init_done(init_done),
    .int_rst(int_rst), .init_active(init_active),
    .serial_busy(serial_busy), .hout_standby(hout_standby)
  );

  rstseq_top dut_full (
    .clk(clk), .rst_pin_n(rst_pin_n), .init_done(1'b0),
    .int_rst(f_int_rst), .init_active(f_init_active),
    .serial_busy(f_serial_busy), .hout_standby(f_hout_standby)
  );

  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {int_rst, init_active, serial_busy, hout_standby};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic hold_reset(input bit done_val);
    @(negedge clk);
    rst_pin_n = 1'b0;
    init_done = done_val;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1", P_RST);
    end
  endtask

  // Release, then follow the edges up to the entry into initialization.
  task automatic release_to_init(input string req);
    rst_pin_n = 1'b1;
    for (int n = 1; n <= SS + H; n++) begin
      @(negedge clk);
      chk(req, P_RST);
    end
    @(negedge clk);
    chk("R3", P_INIT);
  endtask

  task automatic run_seq(input int d);
    hold_reset(1'b0);
    release_to_init("R2");
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      chk("R4", P_INIT);
    end
    init_done = 1'b1;
    @(negedge clk);
    chk("R6", P_RUN);
    init_done = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9", P_RUN);
    end
    init_done = 1'b1;
    @(negedge clk);
    init_done = 1'b0;
    @(negedge clk);
    chk("R7", P_RUN);
  endtask

  initial begin
    #1 rst_pin_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1", P_RST);

    // R2/R3/R4/R6/R9: sweep the completion delay
    for (int d = 0; d <= 6; d++) run_seq(d);

    // R7: done held high through reset and hold changes no phase length
    hold_reset(1'b1);
    release_to_init("R7");
    @(negedge clk);
    chk("R7", P_RUN);
    init_done = 1'b0;

    // R8: abort at every edge position of the sequence, then rerun
    for (int k = 1; k <= SS + H + 4; k++) begin
      hold_reset(1'b0);
      rst_pin_n = 1'b1;
      for (int i = 0; i < k; i++) @(negedge clk);
      rst_pin_n = 1'b0;
      @(negedge clk);
      chk("R8", P_RST);
      @(negedge clk);
      chk("R8", P_RST);
      release_to_init("R8");
      init_done = 1'b1;
      @(negedge clk);
      chk("R8", P_RUN);
      init_done = 1'b0;
    end

    // R8: a pin drop in normal operation
    rst_pin_n = 1'b0;
    @(negedge clk);
    chk("R8", P_RST);

    // R2: default configuration, 81-cycle hold
    begin
      int n;
      @(negedge clk);
      rst_pin_n = 1'b1;
      n = 0;
      while (f_int_rst === 1'b1 && n < 400) begin
        @(negedge clk);
        n++;
      end
      checks++;
      if (n != 84 || f_init_active !== 1'b1 || f_hout_standby !== 1'b0) begin
        errors++;
        $display("FAIL R2: default int_rst fell after %0d edges expected 84 (init=%b stby=%b)",
                 n, f_init_active, f_hout_standby);
      end
      checks++;
      if (f_serial_busy !== 1'b1) begin
        errors++;
        $display("FAIL R4: default serial_busy %b expected 1", f_serial_busy);
      end
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule